// File: doc/BRIEF.md
# Bidirectional Shift/Storage Register Pair

This block pairs a 16-bit serial-in shift register with a 16-bit storage register. Data moves between them under an active-low chip select and a read/write level. In write direction, serial data is clocked into the shift register and a store strobe copies the whole word into storage. In read direction, the stored word is loaded back into the shift register so it can be shifted out serially. The storage word is always visible on a 16-bit parallel output, and the last shift register stage drives a serial output.

The design runs on one fast system clock. The shift strobe, store strobe, chip select, read/write and serial input pins pass through a synchroniser chain of equal depth, so they stay aligned in time. Strobe edges are found by comparing each synchronised strobe with its value from the previous cycle. Each edge is then qualified by the chip select and read/write levels present in that same cycle. As a result, a change on chip select or read/write while a strobe is high never acts as a clock edge.

Top module: `shift_store_pair`

## Requirements
- R1: A synchronous active-low reset clears both registers, so `serialOut` is 0 and `parOut` is 16'h0000.
- R2: While `chipSelN` is 1, no edge on either strobe changes the shift register or the storage register.
- R3: With `chipSelN`=0 and `readWrite`=0 (write), each falling edge of `shiftStrobe` shifts right: `serialIn` enters bit 0 and bit i moves to bit i+1.
- R4: With `chipSelN`=0, `readWrite`=1 (read) and `storeStrobe` low, a falling edge of `shiftStrobe` also shifts right, as in R3.
- R5: With `chipSelN`=0, `readWrite`=1 and `storeStrobe` high, a falling edge of `shiftStrobe` copies the storage word into the shift register, and no shift takes place on that edge.
- R6: `serialOut` always equals bit 15 of the shift register.
- R7: A rising edge of `storeStrobe` copies the shift register into storage only when `chipSelN`=0 and `readWrite`=0. Otherwise storage holds.
- R8: `parOut[i]` equals bit i of the storage register for every i.
- R9: A change on `chipSelN`, `readWrite` or `serialIn` alone, or a rising shift edge or falling store edge, leaves both registers unchanged. A qualifying edge takes effect within SYNC_STAGES+1 clock cycles.
- R10: In write mode, if a shift falling edge and a store rising edge arrive in the same cycle, storage receives the shift register contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| chipSelN | input | 1 | Chip select, active low |
| readWrite | input | 1 | 1 = read direction, 0 = write direction |
| shiftStrobe | input | 1 | Shift strobe, acts on its falling edge |
| storeStrobe | input | 1 | Store strobe, acts on its rising edge |
| serialIn | input | 1 | Serial data into bit 0 |
| serialOut | output | 1 | Shift register bit 15 |
| parOut | output | 16 | Storage register contents |

## Verification
A corrupted shift register shows on `serialOut` at once, but only for bit 15. The lower bits surface one per shift edge, or all together after a store edge copies them to `parOut`. A wrong storage word shows on `parOut` within the sync latency of the faulty edge. The bench therefore compares both outputs after every single input change. It also runs long serial write/read round trips, so that any shift-register bit that went wrong is carried to the ports.

// File: rtl/shift_store_pkg.sv
package shift_store_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic storeEn;
  } regStrobes_t;
endpackage

// File: rtl/level_sync.sv
module level_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/shift_store_ctrl.sv
module shift_store_ctrl
  import shift_store_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipSelN,
  input  logic        readWrite,
  input  logic        shiftStrobe,
  input  logic        storeStrobe,
  input  logic        serialIn,
  output regStrobes_t strobes,
  output logic        serialInSync
);
  localparam int NUM_SYNC = 5;

  logic [NUM_SYNC-1:0] rawBus;
  logic [NUM_SYNC-1:0] syncBus;
  logic csNSync, rwSync, shSync, stSync;
  logic shPrev, stPrev;
  logic shFall, stRise;

  assign rawBus = {serialIn, storeStrobe, shiftStrobe, readWrite, chipSelN};

  level_sync #(.WIDTH(NUM_SYNC), .STAGES(SYNC_STAGES)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rawBus),
    .syncOut(syncBus)
  );

  assign csNSync      = syncBus[0];
  assign rwSync       = syncBus[1];
  assign shSync       = syncBus[2];
  assign stSync       = syncBus[3];
  assign serialInSync = syncBus[4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shPrev <= 1'b0;
      stPrev <= 1'b0;
    end else begin
      shPrev <= shSync;
      stPrev <= stSync;
    end
  end

  assign shFall = shPrev & ~shSync;
  assign stRise = stSync & ~stPrev;

  always_comb begin
    strobes = '0;
    if (!csNSync) begin
      if (shFall) begin
        if (rwSync && stSync) strobes.loadEn  = 1'b1;
        else                  strobes.shiftEn = 1'b1;
      end
      if (stRise && !rwSync) strobes.storeEn = 1'b1;
    end
  end

  AST_LOAD_EXCLUDES_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.shiftEn && strobes.loadEn)); // R5
  AST_STORE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeEn |-> (!csNSync && !rwSync && !stPrev)); // R7
  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csNSync |-> (strobes == '0)); // R2
endmodule

// File: rtl/shift_store_datapath.sv
module shift_store_datapath
  import shift_store_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      strobes,
  input  logic             serialInSync,
  output logic [WIDTH-1:0] shiftReg,
  output logic [WIDTH-1:0] storeReg
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.loadEn) begin
      shiftReg <= storeReg;
    end else if (strobes.shiftEn) begin
      shiftReg <= {shiftReg[WIDTH-2:0], serialInSync};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                storeReg <= '0;
    else if (strobes.storeEn) storeReg <= shiftReg;
  end

  AST_SHIFT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.shiftEn || strobes.loadEn) |=> $stable(shiftReg)); // R9
  AST_STORE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.storeEn |=> $stable(storeReg)); // R7
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEn |=> (shiftReg == $past(storeReg))); // R5
  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> (shiftReg[WIDTH-1:1] == $past(shiftReg[WIDTH-2:0]))); // R3
endmodule

// File: rtl/shift_store_pair.sv
module shift_store_pair
  import shift_store_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSelN,
  input  logic             readWrite,
  input  logic             shiftStrobe,
  input  logic             storeStrobe,
  input  logic             serialIn,
  output logic             serialOut,
  output logic [WIDTH-1:0] parOut
);
  regStrobes_t      strobes;
  logic             serialInSync;
  logic [WIDTH-1:0] shiftReg;
  logic [WIDTH-1:0] storeReg;

  shift_store_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .chipSelN    (chipSelN),
    .readWrite   (readWrite),
    .shiftStrobe (shiftStrobe),
    .storeStrobe (storeStrobe),
    .serialIn    (serialIn),
    .strobes     (strobes),
    .serialInSync(serialInSync)
  );

  shift_store_datapath #(.WIDTH(WIDTH)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .serialInSync(serialInSync),
    .shiftReg    (shiftReg),
    .storeReg    (storeReg)
  );

  assign serialOut = shiftReg[WIDTH-1];
  assign parOut    = storeReg;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (parOut == '0 && !serialOut)); // R1
endmodule

// File: tb/sim_shift_store_pair.sv
module sim_shift_store_pair;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSelN = 1'b1, readWrite = 1'b0, shiftStrobe = 1'b0, storeStrobe = 1'b0, serialIn = 1'b0;
  logic serialOut;
  logic [15:0] parOut;

  int vectors = 0;
  int fails = 0;
  logic [15:0] mShift = '0, mStore = '0;

  always #4 clk = ~clk;

  shift_store_pair u0 (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .readWrite(readWrite),
    .shiftStrobe(shiftStrobe), .storeStrobe(storeStrobe), .serialIn(serialIn),
    .serialOut(serialOut), .parOut(parOut)
  );

  task automatic check(input string req);
    vectors++;
    if (parOut !== mStore) begin
      fails++;
      $display("FAIL %s parOut act=%h exp=%h", req, parOut, mStore);
    end
    if (serialOut !== mShift[15]) begin
      fails++;
      $display("FAIL %s serialOut act=%b exp=%b", req, serialOut, mShift[15]);
    end
  endtask

  // Apply new pin levels, update the model from old->new edges, wait, check.
  task automatic step(input logic cs, input logic rw, input logic sh, input logic st,
                      input logic si, input string req);
    logic shF, stR;
    logic [15:0] oldShift;
    shF = shiftStrobe && !sh;
    stR = !storeStrobe && st;
    oldShift = mShift;
    if (!cs) begin
      if (shF) begin
        if (rw && st) mShift = mStore;
        else          mShift = {mShift[14:0], si};
      end
      if (stR && !rw) mStore = oldShift;
    end
    @(negedge clk);
    chipSelN = cs; readWrite = rw; shiftStrobe = sh; storeStrobe = st; serialIn = si;
    repeat (4) @(negedge clk);
    check(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    logic [15:0] pattern;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1");

    // Directed write: shift in a pattern, then store.
    pattern = 16'hA5C3;
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    for (int i = 15; i >= 0; i--) begin
      step(1'b0, 1'b0, 1'b1, 1'b0, pattern[i], "R9");
      step(1'b0, 1'b0, 1'b0, 1'b0, pattern[i], "R3");
    end
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    // Deselected strobes do nothing.
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    // Read with store low shifts.
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
    // Read with store high reloads.
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    // Shift the stored word back out, checking every bit.
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    end
    // Simultaneous shift fall and store rise in write mode.
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R9");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");

    // Constrained random: one pin changes per step.
    for (int n = 0; n < 3000; n++) begin
      logic cs, rw, sh, st, si;
      cs = chipSelN; rw = readWrite; sh = shiftStrobe; st = storeStrobe; si = serialIn;
      case ($urandom % 8)
        0:       cs = ($urandom % 4 == 0);
        1:       rw = ~rw;
        2, 3, 4: sh = ~sh;
        5, 6:    st = ~st;
        default: si = $urandom % 2;
      endcase
      step(cs, rw, sh, st, si, "R3 R4 R5 R7 R9");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule